// File: doc/BRIEF.md
# Error-Resilient Segmented Dot-Product Engine

This engine computes signed 8-bit dot products between an activation stream and weight data that arrives in fixed 8-element segments. Each segment carries an 8-bit SECDED check field over its 64 weight bits. A checker tests every segment when it is accepted. Clean segments go to a multiply-accumulate stage that keeps pace with the input. Segments that fail the check go into a small side queue. A multi-cycle corrector drains that queue on its own path, so it does not slow the clean stream.

A result row is opened by giving it a slot number and the number of segments it expects. Segments then name their row and may arrive interleaved with other rows. Corrected segments can therefore finish after clean segments that arrived later. Per-row bookkeeping counts down the outstanding segments and offers the 32-bit sum once the count reaches zero. Integer addition does not depend on order, so the sum matches in-order accumulation exactly. A sticky flag reports any segment in the row that could not be repaired.

Top module: `errdp_engine`

## Requirements
- R1: With no bit errors, a row's result equals the sum over its segments of the eight products w[j]*a[j]. Weight lane j is seg_wgt[8j+7:8j] and activation lane j is seg_act[8j+7:8j]. Both are signed two's complement, and the sum is 32-bit signed with no saturation. The error flag is 0.
- R2: The check field protects the weights as a SECDED code. Weight bit i sits at the i-th position in 1..71 that is not a power of two. Check bit k (k=0..6) is the XOR of the weight bits whose position has bit k set. Check bit 7 makes the XOR of all 72 bits zero. A segment with one flipped weight bit contributes its corrected value, and the flag stays 0.
- R3: A segment with one flipped check bit (any of bits 0..7) contributes its unmodified weights, and the flag stays 0.
- R4: A segment with two flipped weight bits sets the row's error flag. The flag stays set for that row until the row is reopened, and it does not affect other rows.
- R5: A row's result is not offered until exactly as many segments as its count have been accumulated. Clean and corrected segments may complete in any order, and the sum is unchanged.
- R6: The side queue holds 4 flagged segments. When it is full, seg_ready is low, and no accepted segment is lost.
- R7: With error-free segments and the result port drained, seg_ready stays high, so one segment is accepted per cycle.
- R8: When a corrected segment and a clean segment are ready for the accumulator in the same cycle, the corrected one is added first. The clean one is held for a cycle and is not lost.
- R9: Up to 4 rows can be open at once. row_start_ready is low for a slot that is open, and it goes high again after that slot's result is accepted.
- R10: While res_valid is high and res_ready is low, res_valid, res_row, res_sum and res_err hold steady.
- R11: After reset, res_valid is 0, seg_ready is 1 and row_start_ready is 1.
- R12: A finished row is placed on the result port as soon as the port is free. When several finished rows are waiting, the lowest row number is offered next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_start_valid | input | 1 | Open a row slot |
| row_start_ready | output | 1 | Slot named by row_start_id is free |
| row_start_id | input | 2 | Slot to open |
| row_start_count | input | 8 | Segments the row expects (at least 1) |
| seg_valid | input | 1 | Segment present |
| seg_ready | output | 1 | Segment accepted this cycle when valid |
| seg_row | input | 2 | Row the segment belongs to |
| seg_wgt | input | 64 | Eight signed 8-bit weights |
| seg_ecc | input | 8 | SECDED check field over seg_wgt |
| seg_act | input | 64 | Eight signed 8-bit activations |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Result taken |
| res_row | output | 2 | Row of the offered result |
| res_sum | output | 32 | Signed accumulated sum |
| res_err | output | 1 | Some segment of the row was uncorrectable |

## Verification
The bench uses the default parameters: eight 8-bit lanes, four row slots, a four-entry side queue and a three-cycle corrector. Because the corrector takes three cycles per segment while the input can deliver one segment per cycle, a burst of faulty segments fills the queue, which exercises the back-pressure path. The same setting makes a corrected segment collide with a clean one at the accumulator when faulty and clean segments alternate. Four slots are enough to fill every slot, stall the result port, and observe which row is offered next.

// File: rtl/errdp_pkg.sv
package errdp_pkg;

   localparam int CODE_DW  = 64;
   localparam int CODE_PW  = 7;
   localparam int CODE_EW  = CODE_PW + 1;
   localparam int CODE_MAX = CODE_DW + CODE_PW;

   // Hamming check bits: data bits fill the non-power-of-two positions.
   function automatic logic [CODE_PW-1:0] ham_bits(input logic [CODE_DW-1:0] d);
      logic [CODE_PW-1:0] p;
      int di;
      p  = '0;
      di = 0;
      for (int pos = 1; pos <= CODE_MAX; pos++) begin
         if ((pos & (pos - 1)) != 0) begin
            for (int k = 0; k < CODE_PW; k++)
               if (pos[k]) p[k] = p[k] ^ d[di];
            di++;
         end
      end
      return p;
   endfunction

   // Flip the data bit sitting at codeword position syn, if any.
   function automatic logic [CODE_DW-1:0] ham_fix(input logic [CODE_DW-1:0] d,
                                                  input logic [CODE_PW-1:0] syn);
      logic [CODE_DW-1:0] r;
      int di;
      r  = d;
      di = 0;
      for (int pos = 1; pos <= CODE_MAX; pos++) begin
         if ((pos & (pos - 1)) != 0) begin
            if (pos[CODE_PW-1:0] == syn) r[di] = ~r[di];
            di++;
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/errdp_checker.sv
module errdp_checker
   import errdp_pkg::*;
(
   input  logic [CODE_DW-1:0] data,
   input  logic [CODE_EW-1:0] ecc,
   output logic [CODE_PW-1:0] syn,
   output logic               par,
   output logic               flag
);
   always_comb begin
      syn  = ham_bits(data) ^ ecc[CODE_PW-1:0];
      par  = ^{ecc, data};
      flag = (syn != '0) || par;
   end
endmodule

// File: rtl/errdp_sideq.sv
module errdp_sideq #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         rd,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("side queue depth must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   used;

   assign empty = (used == '0);
   assign full  = (used == (AW+1)'(DEPTH));
   assign rdata = mem[rp];

   always_ff @(posedge clk) begin
      if (wr) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp   <= '0;
         rp   <= '0;
         used <= '0;
      end else begin
         if (wr) wp <= wp + AW'(1);
         if (rd) rp <= rp + AW'(1);
         case ({wr, rd})
            2'b10:   used <= used + (AW+1)'(1);
            2'b01:   used <= used - (AW+1)'(1);
            default: used <= used;
         endcase
      end
   end

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> !full);
   // R6
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd |-> !empty);
endmodule

// File: rtl/errdp_corrector.sv
module errdp_corrector
   import errdp_pkg::*;
#(
   parameter int RID_W = 2,
   parameter int LAT   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               q_empty,
   output logic               q_rd,
   input  logic [RID_W-1:0]   q_row,
   input  logic [CODE_DW-1:0] q_data,
   input  logic [CODE_EW-1:0] q_ecc,
   input  logic [CODE_DW-1:0] q_act,
   output logic               fix_v,
   output logic [RID_W-1:0]   fix_row,
   output logic [CODE_DW-1:0] fix_data,
   output logic [CODE_DW-1:0] fix_act,
   output logic               fix_bad
);
   logic               busy, last;
   logic [CODE_DW-1:0] h_data;
   logic [CODE_EW-1:0] h_ecc;
   logic [CODE_PW-1:0] syn;
   logic               par, flag_unused;

   errdp_checker u_chk (.data(h_data), .ecc(h_ecc), .syn(syn), .par(par), .flag(flag_unused));

   assign fix_v = busy && last;
   assign q_rd  = !q_empty && (!busy || fix_v);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy <= 1'b0;
      else if (q_rd) busy <= 1'b1;
      else if (fix_v) busy <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (q_rd) begin
         fix_row <= q_row;
         h_data  <= q_data;
         h_ecc   <= q_ecc;
         fix_act <= q_act;
      end
   end

   if (LAT > 1) begin : g_multi
      localparam int CW = $clog2(LAT);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cnt <= '0;
         else if (q_rd) cnt <= CW'(LAT - 1);
         else if (busy && cnt != '0) cnt <= cnt - CW'(1);
      end
      assign last = (cnt == '0);

      // R2
      fix_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
         fix_v |=> !fix_v);
   end else begin : g_single
      assign last = 1'b1;
   end

   always_comb begin
      fix_bad  = ((syn != '0) && !par) || (int'(syn) > CODE_MAX);
      fix_data = (par && !fix_bad) ? ham_fix(h_data, syn) : h_data;
   end
endmodule

// File: rtl/errdp_dotlane.sv
module errdp_dotlane #(
   parameter int LANES = 8,
   parameter int EW    = 8,
   parameter int ACC_W = 32
) (
   input  logic [LANES*EW-1:0]     w,
   input  logic [LANES*EW-1:0]     a,
   output logic signed [ACC_W-1:0] dot
);
   logic signed [2*EW-1:0] prod [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign prod[g] = $signed(w[g*EW +: EW]) * $signed(a[g*EW +: EW]);
   end

   always_comb begin
      dot = '0;
      for (int i = 0; i < LANES; i++) dot = dot + ACC_W'(prod[i]);
   end
endmodule

// File: rtl/errdp_scoreboard.sv
module errdp_scoreboard #(
   parameter int ROWS  = 4,
   parameter int RID_W = 2,
   parameter int CNT_W = 8,
   parameter int ACC_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_valid,
   output logic                    start_ready,
   input  logic [RID_W-1:0]        start_id,
   input  logic [CNT_W-1:0]        start_count,
   input  logic                    upd_v,
   input  logic [RID_W-1:0]        upd_row,
   input  logic signed [ACC_W-1:0] upd_val,
   input  logic                    upd_bad,
   output logic                    res_valid,
   input  logic                    res_ready,
   output logic [RID_W-1:0]        res_row,
   output logic signed [ACC_W-1:0] res_sum,
   output logic                    res_err
);
   logic [ROWS-1:0]         busy, bad, done, cand, held;
   logic [CNT_W-1:0]        left [ROWS];
   logic signed [ACC_W-1:0] acc  [ROWS];
   logic                    out_v, start_fire, res_fire;
   logic [RID_W-1:0]        out_row, nxt_row;

   assign start_ready = !busy[start_id];
   assign start_fire  = start_valid && start_ready;
   assign res_fire    = out_v && res_ready;

   always_comb begin
      for (int r = 0; r < ROWS; r++) done[r] = busy[r] && (left[r] == '0);
      held = out_v ? (ROWS'(1) << out_row) : '0;
      cand = done & ~held;
      nxt_row = '0;
      for (int r = ROWS - 1; r >= 0; r--)
         if (cand[r]) nxt_row = RID_W'(r);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= '0;
         bad  <= '0;
         for (int r = 0; r < ROWS; r++) begin
            left[r] <= '0;
            acc[r]  <= '0;
         end
      end else begin
         for (int r = 0; r < ROWS; r++) begin
            if (start_fire && start_id == RID_W'(r)) begin
               busy[r] <= 1'b1;
               bad[r]  <= 1'b0;
               left[r] <= start_count;
               acc[r]  <= '0;
            end else begin
               if (upd_v && upd_row == RID_W'(r)) begin
                  acc[r]  <= acc[r] + upd_val;
                  left[r] <= left[r] - CNT_W'(1);
                  bad[r]  <= bad[r] | upd_bad;
               end
               if (res_fire && out_row == RID_W'(r)) busy[r] <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_v   <= 1'b0;
         out_row <= '0;
      end else if (!out_v || res_fire) begin
         out_v   <= |cand;
         out_row <= nxt_row;
      end
   end

   assign res_valid = out_v;
   assign res_row   = out_row;
   assign res_sum   = acc[out_row];
   assign res_err   = bad[out_row];

   // R5
   upd_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_v |-> busy[upd_row] && (left[upd_row] != '0));
   // R10
   res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !res_ready |=> res_valid && $stable(res_row) && $stable(res_sum) && $stable(res_err));
   // R9
   start_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_fire |=> !busy[$past(out_row)]);
endmodule

// File: rtl/errdp_engine.sv
module errdp_engine
   import errdp_pkg::*;
#(
   parameter int LANES   = 8,
   parameter int EW      = 8,
   parameter int ACC_W   = 32,
   parameter int ROWS    = 4,
   parameter int CNT_W   = 8,
   parameter int QDEPTH  = 4,
   parameter int FIX_LAT = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      row_start_valid,
   output logic                      row_start_ready,
   input  logic [$clog2(ROWS)-1:0]   row_start_id,
   input  logic [CNT_W-1:0]          row_start_count,
   input  logic                      seg_valid,
   output logic                      seg_ready,
   input  logic [$clog2(ROWS)-1:0]   seg_row,
   input  logic [LANES*EW-1:0]       seg_wgt,
   input  logic [CODE_EW-1:0]        seg_ecc,
   input  logic [LANES*EW-1:0]       seg_act,
   output logic                      res_valid,
   input  logic                      res_ready,
   output logic [$clog2(ROWS)-1:0]   res_row,
   output logic signed [ACC_W-1:0]   res_sum,
   output logic                      res_err
);
   localparam int DW    = LANES * EW;
   localparam int RID_W = $clog2(ROWS);
   localparam int QW    = RID_W + DW + CODE_EW + DW;

   if (DW != CODE_DW) begin : g_bad_dw
      $error("LANES*EW must equal the protected word width");
   end
   if (ROWS < 2) begin : g_bad_rows
      $error("ROWS must be at least 2");
   end
   if (ACC_W < 2 * EW + $clog2(LANES)) begin : g_bad_acc
      $error("ACC_W too narrow for one segment");
   end
   if (FIX_LAT < 1) begin : g_bad_lat
      $error("FIX_LAT must be at least 1");
   end

   // entry checker
   logic [CODE_PW-1:0] in_syn;
   logic               in_par, in_flag;
   errdp_checker u_in_chk (.data(seg_wgt), .ecc(seg_ecc), .syn(in_syn), .par(in_par), .flag(in_flag));

   // side queue
   logic          q_wr, q_rd, q_empty, q_full;
   logic [QW-1:0] q_wdata, q_rdata;
   logic [RID_W-1:0]   q_row;
   logic [DW-1:0]      q_data, q_act;
   logic [CODE_EW-1:0] q_ecc;

   assign q_wdata = {seg_row, seg_wgt, seg_ecc, seg_act};
   assign {q_row, q_data, q_ecc, q_act} = q_rdata;

   errdp_sideq #(.W(QW), .DEPTH(QDEPTH)) u_q (
      .clk(clk), .rst_n(rst_n), .wr(q_wr), .wdata(q_wdata),
      .rd(q_rd), .rdata(q_rdata), .empty(q_empty), .full(q_full));

   // corrector path
   logic               fix_v, fix_bad;
   logic [RID_W-1:0]   fix_row;
   logic [DW-1:0]      fix_data, fix_act;
   logic signed [ACC_W-1:0] fix_prod;

   errdp_corrector #(.RID_W(RID_W), .LAT(FIX_LAT)) u_fix (
      .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_rd(q_rd),
      .q_row(q_row), .q_data(q_data), .q_ecc(q_ecc), .q_act(q_act),
      .fix_v(fix_v), .fix_row(fix_row), .fix_data(fix_data),
      .fix_act(fix_act), .fix_bad(fix_bad));

   errdp_dotlane #(.LANES(LANES), .EW(EW), .ACC_W(ACC_W)) u_fix_dot (
      .w(fix_data), .a(fix_act), .dot(fix_prod));

   // clean MAC lane
   logic signed [ACC_W-1:0] in_prod, clean_prod;
   logic                    clean_v, seg_fire, clean_load, clean_take;
   logic [RID_W-1:0]        clean_row;

   errdp_dotlane #(.LANES(LANES), .EW(EW), .ACC_W(ACC_W)) u_in_dot (
      .w(seg_wgt), .a(seg_act), .dot(in_prod));

   assign seg_ready  = !q_full && !(clean_v && fix_v);
   assign seg_fire   = seg_valid && seg_ready;
   assign q_wr       = seg_fire && in_flag;
   assign clean_load = seg_fire && !in_flag;
   assign clean_take = clean_v && !fix_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clean_v <= 1'b0;
      else if (clean_load) clean_v <= 1'b1;
      else if (clean_take) clean_v <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (clean_load) begin
         clean_row  <= seg_row;
         clean_prod <= in_prod;
      end
   end

   // accumulator select: corrected segment wins
   logic                    upd_v, upd_bad;
   logic [RID_W-1:0]        upd_row;
   logic signed [ACC_W-1:0] upd_val;

   always_comb begin
      upd_v   = fix_v || clean_v;
      upd_row = fix_v ? fix_row  : clean_row;
      upd_val = fix_v ? fix_prod : clean_prod;
      upd_bad = fix_v && fix_bad;
   end

   errdp_scoreboard #(.ROWS(ROWS), .RID_W(RID_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_sb (
      .clk(clk), .rst_n(rst_n),
      .start_valid(row_start_valid), .start_ready(row_start_ready),
      .start_id(row_start_id), .start_count(row_start_count),
      .upd_v(upd_v), .upd_row(upd_row), .upd_val(upd_val), .upd_bad(upd_bad),
      .res_valid(res_valid), .res_ready(res_ready), .res_row(res_row),
      .res_sum(res_sum), .res_err(res_err));

   // R8
   clean_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clean_v && fix_v |=> clean_v && $stable(clean_prod) && $stable(clean_row));
   // R6
   full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_full |-> !seg_ready);
   // R7
   clean_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clean_load |=> clean_v);
endmodule

// File: tb/tb_errdp_engine.sv
`timescale 1ns/1ps
module tb_errdp_engine;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        row_start_valid, row_start_ready;
   logic [1:0]  row_start_id;
   logic [7:0]  row_start_count;
   logic        seg_valid, seg_ready;
   logic [1:0]  seg_row;
   logic [63:0] seg_wgt, seg_act;
   logic [7:0]  seg_ecc;
   logic        res_valid, res_ready, res_err;
   logic [1:0]  res_row;
   logic signed [31:0] res_sum;

   int n_tests = 0, n_fail = 0, stalls = 0, rec_n = 0;
   int rec_row [64];
   int rec_sum [64];
   int rec_err [64];
   logic [31:0] seed = 32'h1234_5678;

   always #4 clk = ~clk;

   errdp_engine dut (
      .clk(clk), .rst_n(rst_n),
      .row_start_valid(row_start_valid), .row_start_ready(row_start_ready),
      .row_start_id(row_start_id), .row_start_count(row_start_count),
      .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_row(seg_row),
      .seg_wgt(seg_wgt), .seg_ecc(seg_ecc), .seg_act(seg_act),
      .res_valid(res_valid), .res_ready(res_ready), .res_row(res_row),
      .res_sum(res_sum), .res_err(res_err));

   always @(negedge clk) begin
      if (rst_n && res_valid && res_ready && rec_n < 64) begin
         rec_row[rec_n] = int'(res_row);
         rec_sum[rec_n] = int'(res_sum);
         rec_err[rec_n] = int'(res_err);
         rec_n++;
      end
   end

   function automatic logic [63:0] rnd64();
      logic [63:0] v;
      for (int i = 0; i < 2; i++) begin
         seed = seed * 32'd1103515245 + 32'd12345;
         v = {v[31:0], seed};
      end
      return v;
   endfunction

   function automatic int dot_ref(input logic [63:0] w, input logic [63:0] a);
      int s = 0;
      for (int i = 0; i < 8; i++) s += $signed(w[i*8 +: 8]) * $signed(a[i*8 +: 8]);
      return s;
   endfunction

   // codeword by position, then parity per position bit
   function automatic logic [7:0] enc_ref(input logic [63:0] d);
      logic [71:0] cw;
      logic [7:0]  e;
      int di = 0;
      cw = '0;
      for (int pos = 3; pos < 72; pos++) begin
         if (pos != 4 && pos != 8 && pos != 16 && pos != 32 && pos != 64) begin
            cw[pos] = d[di];
            di++;
         end
      end
      e = '0;
      for (int k = 0; k < 7; k++)
         for (int pos = 1; pos < 72; pos++)
            if (((pos >> k) & 1) == 1) e[k] = e[k] ^ cw[pos];
      e[7] = (^d) ^ (^e[6:0]);
      return e;
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic start_row(input int id, input int cnt);
      logic rdy;
      row_start_valid = 1'b1;
      row_start_id    = 2'(id);
      row_start_count = 8'(cnt);
      forever begin
         #1 rdy = row_start_ready;
         @(negedge clk);
         if (rdy) break;
      end
      row_start_valid = 1'b0;
   endtask

   task automatic send_seg(input int row, input logic [63:0] w, input logic [63:0] a,
                           input logic [71:0] flip);
      logic [71:0] cw;
      logic rdy;
      cw = {enc_ref(w), w} ^ flip;
      seg_valid = 1'b1;
      seg_row   = 2'(row);
      seg_wgt   = cw[63:0];
      seg_ecc   = cw[71:64];
      seg_act   = a;
      forever begin
         #1 rdy = seg_ready;
         @(negedge clk);
         if (rdy) break;
         stalls++;
      end
      seg_valid = 1'b0;
   endtask

   task automatic set_rr(input logic v);
      @(posedge clk);
      #1 res_ready = v;
      @(negedge clk);
   endtask

   task automatic wait_res(input int n, input string req);
      int t = 0;
      while (rec_n < n && t < 400) begin
         @(negedge clk);
         t++;
      end
      chk(rec_n >= n, req, rec_n, n);
   endtask

   task automatic check_rec(input int idx, input int row, input int sum, input int err,
                            input string req);
      chk(rec_row[idx] == row, req, rec_row[idx], row);
      chk(rec_sum[idx] == sum, req, rec_sum[idx], sum);
      chk(rec_err[idx] == err, req, rec_err[idx], err);
   endtask

   task automatic t_reset();
      row_start_id = 2'd0;
      #1;
      chk(seg_ready == 1'b1, "R11 seg_ready", seg_ready, 1);
      chk(res_valid == 1'b0, "R11 res_valid", res_valid, 0);
      chk(row_start_ready == 1'b1, "R11 row_start_ready", row_start_ready, 1);
      @(negedge clk);
   endtask

   task automatic t_clean();
      int base = rec_n, exp = 0;
      logic [63:0] w, a;
      start_row(0, 3);
      w = {8{8'h80}}; a = {8{8'h80}};
      exp += dot_ref(w, a); send_seg(0, w, a, '0);
      w = rnd64(); a = rnd64();
      exp += dot_ref(w, a); send_seg(0, w, a, '0);
      repeat (6) @(negedge clk);
      chk(res_valid == 1'b0, "R5 early result", res_valid, 0);
      w = rnd64(); a = {8{8'hff}};
      exp += dot_ref(w, a); send_seg(0, w, a, '0);
      wait_res(base + 1, "R1 result arrival");
      check_rec(base, 0, exp, 0, "R1 clean sum");
   endtask

   task automatic t_single_data();
      int base = rec_n, exp = 0;
      int bits [4] = '{0, 17, 40, 63};
      start_row(1, 4);
      foreach (bits[i]) begin
         logic [63:0] w = rnd64(), a = rnd64();
         exp += dot_ref(w, a);
         send_seg(1, w, a, 72'(1) << bits[i]);
      end
      wait_res(base + 1, "R2 result arrival");
      check_rec(base, 1, exp, 0, "R2 data bit fix");
   endtask

   task automatic t_single_check();
      int base = rec_n, exp = 0;
      int bits [3] = '{64, 70, 71};
      start_row(2, 3);
      foreach (bits[i]) begin
         logic [63:0] w = rnd64(), a = rnd64();
         exp += dot_ref(w, a);
         send_seg(2, w, a, 72'(1) << bits[i]);
      end
      wait_res(base + 1, "R3 result arrival");
      check_rec(base, 2, exp, 0, "R3 check bit error");
   endtask

   task automatic t_double();
      int base = rec_n, exp;
      logic [63:0] w, a;
      start_row(3, 2);
      send_seg(3, rnd64(), rnd64(), (72'(1) << 3) | (72'(1) << 9));
      send_seg(3, rnd64(), rnd64(), '0);
      wait_res(base + 1, "R4 result arrival");
      chk(rec_row[base] == 3, "R4 row", rec_row[base], 3);
      chk(rec_err[base] == 1, "R4 sticky flag", rec_err[base], 1);
      start_row(3, 1);
      w = rnd64(); a = rnd64(); exp = dot_ref(w, a);
      send_seg(3, w, a, '0);
      wait_res(base + 2, "R4 reopen arrival");
      check_rec(base + 1, 3, exp, 0, "R4 flag cleared on reopen");
   endtask

   task automatic t_mixed();
      int base = rec_n, exp = 0;
      start_row(1, 6);
      for (int i = 0; i < 6; i++) begin
         logic [63:0] w = rnd64(), a = rnd64();
         exp += dot_ref(w, a);
         send_seg(1, w, a, (i % 2 == 0) ? (72'(1) << (i * 11 + 2)) : 72'(0));
      end
      wait_res(base + 1, "R8 result arrival");
      check_rec(base, 1, exp, 0, "R8 R5 mixed order sum");
   endtask

   task automatic t_burst();
      int base = rec_n, exp = 0;
      stalls = 0;
      start_row(2, 8);
      for (int i = 0; i < 8; i++) begin
         logic [63:0] w = rnd64(), a = rnd64();
         exp += dot_ref(w, a);
         send_seg(2, w, a, 72'(1) << (i * 7 + 1));
      end
      chk(stalls > 0, "R6 back-pressure seen", stalls, 1);
      wait_res(base + 1, "R6 result arrival");
      check_rec(base, 2, exp, 0, "R6 nothing lost");
   endtask

   task automatic t_full_rate();
      int base = rec_n, exp = 0;
      start_row(0, 10);
      stalls = 0;
      for (int i = 0; i < 10; i++) begin
         logic [63:0] w = rnd64(), a = rnd64();
         exp += dot_ref(w, a);
         send_seg(0, w, a, '0);
      end
      chk(stalls == 0, "R7 clean stalls", stalls, 0);
      wait_res(base + 1, "R7 result arrival");
      check_rec(base, 0, exp, 0, "R7 clean stream sum");
   endtask

   task automatic t_rows();
      int base = rec_n, s3;
      int exp [4];
      int order [4] = '{3, 0, 1, 2};
      for (int r = 0; r < 4; r++) start_row(r, 1);
      row_start_id = 2'd2;
      #1 chk(row_start_ready == 1'b0, "R9 open slot blocked", row_start_ready, 0);
      set_rr(1'b0);
      for (int r = 3; r >= 0; r--) begin
         logic [63:0] w = rnd64(), a = rnd64();
         exp[r] = dot_ref(w, a);
         send_seg(r, w, a, '0);
      end
      repeat (10) @(negedge clk);
      chk(res_valid == 1'b1, "R10 offered", res_valid, 1);
      chk(res_row == 2'd3, "R12 first ready row", res_row, 3);
      s3 = int'(res_sum);
      repeat (3) @(negedge clk);
      chk(res_valid == 1'b1 && res_row == 2'd3 && int'(res_sum) == s3, "R10 held", res_sum, s3);
      set_rr(1'b1);
      wait_res(base + 4, "R12 arrivals");
      for (int i = 0; i < 4; i++)
         check_rec(base + i, order[i], exp[order[i]], 0, "R12 order");
      row_start_id = 2'd2;
      #1 chk(row_start_ready == 1'b1, "R9 slot reusable", row_start_ready, 1);
      @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0;
      row_start_valid = 1'b0; row_start_id = '0; row_start_count = '0;
      seg_valid = 1'b0; seg_row = '0; seg_wgt = '0; seg_ecc = '0; seg_act = '0;
      res_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_clean();
      t_single_data();
      t_single_check();
      t_double();
      t_mixed();
      t_burst();
      t_full_rate();
      t_rows();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule